// File: doc/BRIEF.md
# Guaranteed-Rate Thread Resource Governor

This controller sits beside the shared back end of a multithreaded core and holds one chosen hardware thread at a requested fraction of the speed it reaches when it runs alone. It repeats two phases without end. In the first phase, the chosen thread gets every shared resource and the other threads are halted. After a settling period, the controller counts the thread's committed instructions over a fixed window. That count is the reference for its current full speed. In the second phase, the other threads run again, and the controller steers four occupancy limits for the chosen thread against the reference scaled by the requested percentage. The four limits are rename registers, issue queue entries, load/store queue entries and L2 ways.

Software writes the percentage. The pipeline reports how many instructions the chosen thread committed in each cycle. The pipeline and the cache enforce the limits. Other threads may use whatever the chosen thread does not hold. Every phase length, pool size, floor and step is a parameter, so a test can use short phases.

Top module: `qos_alloc_ctrl`

## Requirements
- R1: While `en_i` is high, the block moves from idle to warm-up on the next clock. It then runs WARM_CYC warm-up cycles, SAMP_CYC measurement cycles, and TUNE_NINT tuning intervals of TUNE_INT cycles each, and returns to warm-up. This repeats indefinitely.
- R2: In warm-up and measurement, `halt_others_o` is 1 and every cap output equals its full pool. In idle and tuning, `halt_others_o` is 0.
- R3: The sample reference is the sum of `commit_i` over the SAMP_CYC measurement cycles only. Commits during warm-up have no effect on any decision.
- R4: On the last cycle of each tuning interval, let I be the interval commit sum including that cycle, R the sample reference, and P the latched percentage. The block compares I·SAMP_CYC·100 with R·TUNE_INT·P. If the left side is smaller, all caps go up one step. If it is larger, all caps go down one step. If they are equal, the caps hold. The new caps are visible from the next cycle.
- R5: The step sizes are REG_STEP for registers, IQ_STEP for issue queue, LSQ_STEP for load/store queue and WAY_STEP for L2 ways.
- R6: Each cap stays within its floor (REG_MIN, IQ_MIN, LSQ_MIN, WAY_MIN) and its pool (REG_POOL, IQ_POOL, LSQ_POOL, L2_WAYS). A step that would cross a bound stops at that bound.
- R7: Caps change only at interval ends. They keep their values through warm-up and measurement, so tuning resumes from the values that were in force before the sample phase.
- R8: `pct_i` is latched only when warm-up is entered. Changes at other times have no effect until the next warm-up entry. Values above 100 are treated as 100.
- R9: With `en_i` low, the block is idle from the next clock, `halt_others_o` is 0, and the caps return to their full pools. `commit_i` is ignored.
- R10: After reset, the block is idle, `halt_others_o` is 0, and every cap is at its full pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces idle |
| pct_i | input | 7 | Requested percentage of standalone speed, 0 to 100 |
| commit_i | input | COMMIT_W | Instructions committed this cycle by the chosen thread |
| halt_others_o | output | 1 | Stop all other threads |
| cap_reg_o | output | $clog2(REG_POOL+1) | Rename register limit |
| cap_iq_o | output | $clog2(IQ_POOL+1) | Issue queue entry limit |
| cap_lsq_o | output | $clog2(LSQ_POOL+1) | Load/store queue entry limit |
| cap_way_o | output | $clog2(L2_WAYS+1) | L2 way limit |

## Verification
The hard cases to reach from the ports are the exact-equality hold decision and the carry of caps across a sample phase. During warm-up and measurement the outputs are forced to the full pools, so the carried cap values cannot be seen there. The stimulus keeps the commit rate constant within each interval, so the tuning rate and the reference are in a known integer ratio. That lets chosen percentages land exactly on, just below and just above the threshold. A per-cycle model then checks the caps on the first tuning cycle after each measurement. The stimulus also changes `pct_i` in the middle of tuning and drives a large commit rate during warm-up, so that a wrongly timed latch or count would alter a later cap.

// File: rtl/qos_pkg.sv
package qos_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WARM = 2'd1,
    PH_SAMP = 2'd2,
    PH_TUNE = 2'd3
  } qos_phase_e;

  typedef enum logic [1:0] {
    ADJ_HOLD = 2'd0,
    ADJ_UP   = 2'd1,
    ADJ_DOWN = 2'd2
  } qos_adj_e;

  localparam int unsigned NUM_RES = 4;
  localparam int unsigned PCT_W   = 7;
  localparam int unsigned PCT_MAX = 100;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qos_phase_seq.sv
module qos_phase_seq
  import qos_pkg::*;
#(
  parameter int unsigned WARM_CYC  = 50000,
  parameter int unsigned SAMP_CYC  = 10000,
  parameter int unsigned TUNE_INT  = 15000,
  parameter int unsigned TUNE_NINT = 80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  output qos_phase_e phase_o,
  output logic       load_o,
  output logic       int_end_o
);

  localparam int unsigned LONGEST = umax(umax(WARM_CYC, SAMP_CYC), TUNE_INT);
  localparam int unsigned CNT_W   = $clog2(LONGEST + 1);
  localparam int unsigned NI_W    = $clog2(TUNE_NINT + 1);

  qos_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [NI_W-1:0]   nint_q, nint_d;
  logic              warm_end, samp_end, int_end, last_int;

  assign warm_end = (phase_q == PH_WARM) && (cnt_q == CNT_W'(WARM_CYC - 1));
  assign samp_end = (phase_q == PH_SAMP) && (cnt_q == CNT_W'(SAMP_CYC - 1));
  assign int_end  = (phase_q == PH_TUNE) && (cnt_q == CNT_W'(TUNE_INT - 1));
  assign last_int = (nint_q == NI_W'(TUNE_NINT - 1));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + CNT_W'(1);
    nint_d  = nint_q;
    if (!en_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      nint_d  = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_WARM;
          cnt_d   = '0;
        end
        PH_WARM: if (warm_end) begin
          phase_d = PH_SAMP;
          cnt_d   = '0;
        end
        PH_SAMP: if (samp_end) begin
          phase_d = PH_TUNE;
          cnt_d   = '0;
          nint_d  = '0;
        end
        PH_TUNE: if (int_end) begin
          cnt_d = '0;
          if (last_int) begin
            phase_d = PH_WARM;
            nint_d  = '0;
          end else begin
            nint_d = nint_q + NI_W'(1);
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      nint_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      nint_q  <= nint_d;
    end
  end

  assign phase_o   = phase_q;
  assign load_o    = (phase_d == PH_WARM) && (phase_q != PH_WARM);
  assign int_end_o = int_end;

  // measurement only follows warm-up
  p_samp_after_warm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SAMP && $past(phase_q) != PH_SAMP) |-> $past(phase_q) == PH_WARM);

  // tuning only follows measurement
  p_tune_after_samp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_TUNE && $past(phase_q) != PH_TUNE) |-> $past(phase_q) == PH_SAMP);

  p_idle_on_disable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> phase_q == PH_IDLE);

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(LONGEST));

endmodule

// File: rtl/qos_ipc_meter.sv
module qos_ipc_meter
  import qos_pkg::*;
#(
  parameter int unsigned COMMIT_W = 3,
  parameter int unsigned SAMP_CYC = 10000,
  parameter int unsigned TUNE_INT = 15000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  qos_phase_e          phase_i,
  input  logic                load_i,
  input  logic                int_end_i,
  input  logic [COMMIT_W-1:0] commit_i,
  input  logic [PCT_W-1:0]    pct_i,
  output logic                adj_vld_o,
  output qos_adj_e            adj_o
);

  localparam int unsigned SUM_S_W = COMMIT_W + $clog2(SAMP_CYC + 1);
  localparam int unsigned SUM_I_W = COMMIT_W + $clog2(TUNE_INT + 1);
  localparam int unsigned PROD_W  = COMMIT_W + $clog2(SAMP_CYC + 1)
                                  + $clog2(TUNE_INT + 1) + PCT_W;

  logic [PCT_W-1:0]   pct_q;
  logic [SUM_S_W-1:0] samp_q;
  logic [SUM_I_W-1:0] int_q, int_tot;
  logic [PROD_W-1:0]  lhs, rhs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pct_q <= PCT_W'(PCT_MAX);
    end else if (load_i) begin
      pct_q <= (pct_i > PCT_W'(PCT_MAX)) ? PCT_W'(PCT_MAX) : pct_i;
    end
  end

  // reference count: cleared on warm-up entry, accumulates only in measurement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
    end else if (load_i) begin
      samp_q <= '0;
    end else if (phase_i == PH_SAMP) begin
      samp_q <= samp_q + SUM_S_W'(commit_i);
    end
  end

  assign int_tot = int_q + SUM_I_W'(commit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= '0;
    end else if (phase_i != PH_TUNE || int_end_i) begin
      int_q <= '0;
    end else begin
      int_q <= int_tot;
    end
  end

  // division-free rate compare
  assign lhs = PROD_W'(int_tot) * PROD_W'(SAMP_CYC) * PROD_W'(PCT_MAX);
  assign rhs = PROD_W'(samp_q) * PROD_W'(TUNE_INT) * PROD_W'(pct_q);

  always_comb begin
    if (lhs < rhs)      adj_o = ADJ_UP;
    else if (lhs > rhs) adj_o = ADJ_DOWN;
    else                adj_o = ADJ_HOLD;
  end

  assign adj_vld_o = int_end_i;

  p_pct_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(pct_q));

  p_pct_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pct_q <= PCT_W'(PCT_MAX));

  p_ref_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_SAMP && !load_i) |=> $stable(samp_q));

  p_adj_in_tune_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_vld_o |-> phase_i == PH_TUNE);

endmodule

// File: rtl/qos_cap_ctrl.sv
module qos_cap_ctrl
  import qos_pkg::*;
#(
  parameter int unsigned POOL = 32,
  parameter int unsigned MIN  = 8,
  parameter int unsigned STEP = 4,
  parameter int unsigned W    = $clog2(POOL + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         grant_all_i,
  input  logic         adj_vld_i,
  input  qos_adj_e     adj_i,
  output logic [W-1:0] cap_o
);

  logic [W-1:0] cap_q, cap_up, cap_dn;
  logic [W:0]   up_sum;

  assign up_sum = {1'b0, cap_q} + (W+1)'(STEP);
  assign cap_up = (up_sum > (W+1)'(POOL)) ? W'(POOL) : up_sum[W-1:0];
  assign cap_dn = ({1'b0, cap_q} < (W+1)'(MIN + STEP)) ? W'(MIN) : cap_q - W'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= W'(POOL);
    end else if (clr_i) begin
      cap_q <= W'(POOL);
    end else if (adj_vld_i) begin
      unique case (adj_i)
        ADJ_UP:   cap_q <= cap_up;
        ADJ_DOWN: cap_q <= cap_dn;
        default:  cap_q <= cap_q;
      endcase
    end
  end

  assign cap_o = grant_all_i ? W'(POOL) : cap_q;

  p_cap_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_q >= W'(MIN) && cap_q <= W'(POOL));

  p_cap_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adj_vld_i && !clr_i) |=> $stable(cap_q));

  p_cap_up_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_vld_i && adj_i == ADJ_UP && !clr_i) |=> cap_q >= $past(cap_q));

  p_cap_dn_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_vld_i && adj_i == ADJ_DOWN && !clr_i) |=> cap_q <= $past(cap_q));

endmodule

// File: rtl/qos_alloc_ctrl.sv
module qos_alloc_ctrl
  import qos_pkg::*;
#(
  parameter int unsigned COMMIT_W  = 3,
  parameter int unsigned WARM_CYC  = 50000,
  parameter int unsigned SAMP_CYC  = 10000,
  parameter int unsigned TUNE_INT  = 15000,
  parameter int unsigned TUNE_NINT = 80,
  parameter int unsigned REG_POOL  = 320,
  parameter int unsigned REG_MIN   = 16,
  parameter int unsigned REG_STEP  = 16,
  parameter int unsigned IQ_POOL   = 32,
  parameter int unsigned IQ_MIN    = 8,
  parameter int unsigned IQ_STEP   = 4,
  parameter int unsigned LSQ_POOL  = 32,
  parameter int unsigned LSQ_MIN   = 8,
  parameter int unsigned LSQ_STEP  = 4,
  parameter int unsigned L2_WAYS   = 8,
  parameter int unsigned WAY_MIN   = 1,
  parameter int unsigned WAY_STEP  = 1,
  localparam int unsigned REG_W    = $clog2(REG_POOL + 1),
  localparam int unsigned IQ_W     = $clog2(IQ_POOL + 1),
  localparam int unsigned LSQ_W    = $clog2(LSQ_POOL + 1),
  localparam int unsigned WAY_W    = $clog2(L2_WAYS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [6:0]          pct_i,
  input  logic [COMMIT_W-1:0] commit_i,
  output logic                halt_others_o,
  output logic [REG_W-1:0]    cap_reg_o,
  output logic [IQ_W-1:0]     cap_iq_o,
  output logic [LSQ_W-1:0]    cap_lsq_o,
  output logic [WAY_W-1:0]    cap_way_o
);

  localparam int unsigned POOL_A [NUM_RES] = '{REG_POOL, IQ_POOL, LSQ_POOL, L2_WAYS};
  localparam int unsigned MIN_A  [NUM_RES] = '{REG_MIN,  IQ_MIN,  LSQ_MIN,  WAY_MIN};
  localparam int unsigned STEP_A [NUM_RES] = '{REG_STEP, IQ_STEP, LSQ_STEP, WAY_STEP};

  qos_phase_e phase;
  qos_adj_e   adj;
  logic       load, int_end, adj_vld, grant_all, idle;

  qos_phase_seq #(
    .WARM_CYC (WARM_CYC),
    .SAMP_CYC (SAMP_CYC),
    .TUNE_INT (TUNE_INT),
    .TUNE_NINT(TUNE_NINT)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .phase_o  (phase),
    .load_o   (load),
    .int_end_o(int_end)
  );

  qos_ipc_meter #(
    .COMMIT_W(COMMIT_W),
    .SAMP_CYC(SAMP_CYC),
    .TUNE_INT(TUNE_INT)
  ) u_meter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phase_i  (phase),
    .load_i   (load),
    .int_end_i(int_end),
    .commit_i (commit_i),
    .pct_i    (pct_i),
    .adj_vld_o(adj_vld),
    .adj_o    (adj)
  );

  assign grant_all     = (phase == PH_WARM) || (phase == PH_SAMP) || (phase == PH_IDLE);
  assign idle          = (phase == PH_IDLE);
  assign halt_others_o = (phase == PH_WARM) || (phase == PH_SAMP);

  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    localparam int unsigned GW = $clog2(POOL_A[g] + 1);
    logic [GW-1:0] cap_g;

    qos_cap_ctrl #(
      .POOL(POOL_A[g]),
      .MIN (MIN_A[g]),
      .STEP(STEP_A[g]),
      .W   (GW)
    ) u_cap (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (idle),
      .grant_all_i(grant_all),
      .adj_vld_i  (adj_vld),
      .adj_i      (adj),
      .cap_o      (cap_g)
    );

    if (g == 0) begin : g_reg
      assign cap_reg_o = cap_g;
    end else if (g == 1) begin : g_iq
      assign cap_iq_o = cap_g;
    end else if (g == 2) begin : g_lsq
      assign cap_lsq_o = cap_g;
    end else begin : g_way
      assign cap_way_o = cap_g;
    end
  end

  p_halt_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_others_o |-> (cap_reg_o == REG_W'(REG_POOL) && cap_iq_o == IQ_W'(IQ_POOL) &&
                       cap_lsq_o == LSQ_W'(LSQ_POOL) && cap_way_o == WAY_W'(L2_WAYS)));

  p_release_on_disable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !halt_others_o);

  p_halt_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_others_o) |-> $past(en_i));

endmodule

// File: tb/qos_alloc_ctrl_tb.sv
module qos_alloc_ctrl_tb_top;

  localparam int CW    = 3;
  localparam int WARM  = 4;
  localparam int SAMP  = 8;
  localparam int INTV  = 5;
  localparam int NINT  = 3;
  localparam int POOL [4] = '{32, 16, 12, 8};
  localparam int FLOOR[4] = '{16, 8, 8, 1};
  localparam int STEP [4] = '{8, 4, 4, 2};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [6:0]    pct = 7'd0;
  logic [CW-1:0] commit = '0;
  logic          halt;
  logic [5:0]    cap_reg;
  logic [4:0]    cap_iq;
  logic [3:0]    cap_lsq;
  logic [3:0]    cap_way;

  int checks = 0;
  int fails  = 0;
  int exp_cap[4];
  bit done = 1'b0;

  always #10 clk = ~clk;

  qos_alloc_ctrl #(
    .COMMIT_W(CW), .WARM_CYC(WARM), .SAMP_CYC(SAMP), .TUNE_INT(INTV), .TUNE_NINT(NINT),
    .REG_POOL(32), .REG_MIN(16), .REG_STEP(8),
    .IQ_POOL(16),  .IQ_MIN(8),   .IQ_STEP(4),
    .LSQ_POOL(12), .LSQ_MIN(8),  .LSQ_STEP(4),
    .L2_WAYS(8),   .WAY_MIN(1),  .WAY_STEP(2)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pct_i(pct), .commit_i(commit),
    .halt_others_o(halt), .cap_reg_o(cap_reg), .cap_iq_o(cap_iq),
    .cap_lsq_o(cap_lsq), .cap_way_o(cap_way)
  );

  task automatic check_out(string req, bit eh, int e0, int e1, int e2, int e3);
    checks++;
    if (halt !== eh || int'(cap_reg) != e0 || int'(cap_iq) != e1 ||
        int'(cap_lsq) != e2 || int'(cap_way) != e3) begin
      fails++;
      $display("FAIL %s t=%0t actual halt=%0b caps=%0d/%0d/%0d/%0d expected halt=%0b caps=%0d/%0d/%0d/%0d",
               req, $time, halt, cap_reg, cap_iq, cap_lsq, cap_way, eh, e0, e1, e2, e3);
    end
  endtask

  task automatic check_full(string req, bit eh);
    check_out(req, eh, POOL[0], POOL[1], POOL[2], POOL[3]);
  endtask

  task automatic reset_model();
    for (int r = 0; r < 4; r++) exp_cap[r] = POOL[r];
  endtask

  task automatic apply_decision(int p_eff, int s, int t);
    longint lhs, rhs;
    lhs = longint'(t) * INTV * SAMP * 100;
    rhs = longint'(s) * SAMP * INTV * p_eff;
    for (int r = 0; r < 4; r++) begin
      if (lhs < rhs) begin
        exp_cap[r] = exp_cap[r] + STEP[r];
        if (exp_cap[r] > POOL[r]) exp_cap[r] = POOL[r];
      end else if (lhs > rhs) begin
        exp_cap[r] = exp_cap[r] - STEP[r];
        if (exp_cap[r] < FLOOR[r]) exp_cap[r] = FLOOR[r];
      end
    end
  endtask

  // one full round from warm-up entry; abort_k >= 0 drops enable in that interval
  task automatic run_round(int p_raw, int p_next, int wv, int s,
                           int t0, int t1, int t2, int abort_k);
    int p_eff;
    int tv[3];
    p_eff = (p_raw > 100) ? 100 : p_raw;
    tv[0] = t0; tv[1] = t1; tv[2] = t2;
    for (int j = 0; j < WARM; j++) begin
      @(negedge clk);
      check_full("R1 R2 warm-up", 1'b1);
      commit = CW'(wv);
    end
    for (int j = 0; j < SAMP; j++) begin
      @(negedge clk);
      check_full("R2 measurement", 1'b1);
      commit = CW'(s);
    end
    for (int k = 0; k < NINT; k++) begin
      for (int i = 0; i < INTV; i++) begin
        @(negedge clk);
        check_out("R3 R4 R5 R6 R7 R8 tuning", 1'b0,
                  exp_cap[0], exp_cap[1], exp_cap[2], exp_cap[3]);
        if (k == abort_k && i == 2) begin
          en = 1'b0;
          return;
        end
        commit = CW'(tv[k]);
        if (k == 0 && i == 1) pct = 7'(p_next);
      end
      apply_decision(p_eff, s, tv[k]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int sweep[5];
    sweep = '{25, 50, 75, 100, 120};
    reset_model();
    commit = CW'(5);
    repeat (3) @(negedge clk);
    check_full("R10 reset", 1'b0);
    rst_n = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check_full("R10 R9 idle after reset", 1'b0);
    end
    en  = 1'b1;
    pct = 7'd50;
    run_round(50, 127, 7, 4, 2, 3, 1, -1);   // hold, lower, raise
    run_round(127, 0, 0, 2, 3, 3, 2, -1);    // 127 treated as 100
    run_round(0, 10, 7, 3, 0, 1, 0, -1);     // zero target
    run_round(10, 10, 7, 7, 7, 7, 7, -1);    // lower toward floors
    run_round(10, sweep[0], 7, 7, 7, 7, 7, -1);
    for (int n = 0; n < 5; n++) begin
      run_round(sweep[n], (n == 4) ? 100 : sweep[n+1], 6, 4, 2, 2, 2, -1);
    end
    run_round(100, 100, 0, 1, 0, 0, 0, -1);  // raise to pools
    run_round(100, 60, 0, 7, 7, 6, 7, 1);    // disable mid-tune
    reset_model();
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check_full("R9 disabled", 1'b0);
      commit = CW'(7);
    end
    en  = 1'b1;
    pct = 7'd60;
    run_round(60, 60, 0, 5, 3, 4, 2, -1);    // hold at exact threshold after restart
    run_round(60, 60, 0, 5, 4, 4, 4, -1);
    @(negedge clk);
    check_full("R1 R7 back to warm-up", 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule